// File: doc/BRIEF.md
# Outer Cache Maintenance Walker

This block is the control front end of an outer cache for maintenance requests issued by software. Over a small register bus, software can switch the cache on or off, set two auxiliary enables, load a first line index and an exclusive last line index, and then start a clean, invalidate or flush. The request covers either the whole cache or the loaded range of lines. Line indices are physical address bits 35:6 of a 36-bit space, with 64-byte lines.

Once started, the walker steps through every line index in the requested set. In whole-cache mode these are the set/way indices 0 up to a parameterised count; in range mode they are the start index up to one below the end index. For each index it presents one single-line command on a valid/ready interface. The start bit of the maintenance register reads back as a busy flag until the walk is over, and software polls that flag. While a walk runs, the walk's own registers are write-protected.

Top module: `cmo_range_seq`

## Requirements
- R1: After reset, every register reads 0. The cache enable output and both auxiliary enables are low, and no line command is presented.
- R2: A bus read or write is accepted in the cycle it is presented. `bus_ready` is high in exactly the following cycle, and a read's data is valid with it. A read of any unmapped offset returns 0.
- R3: Bit 0 of the register at offset 0x00 is read/write and drives `cache_en`.
- R4: The register at offset 0x04 stores only bit 23 (drives `evt_en`) and bit 8 (drives `ecc_en`). All other bits read 0.
- R5: In the register at offset 0x20, bit 3 selects scope (0 whole cache, 1 range) and bits 2:1 hold the operation (1 clean, 2 invalidate, 3 flush). Both fields read back as written. Writing bit 0 as 1 starts a walk, and bit 0 reads 1 while the walk is busy.
- R6: Offsets 0x24 (start) and 0x28 (end) each hold a 30-bit line index in bits 29:0. Bits 31:30 read 0.
- R7: A range walk issues the indices start, start+1, …, end-1 in ascending order. End is exclusive.
- R8: A whole-cache walk issues the indices 0 to SETWAYS-1 in ascending order.
- R9: `line_valid`, `line_idx` and `line_op` are held stable until `line_ready` is high. The walker moves to the next index only in a cycle where valid and ready are both high. `line_op` equals the operation code written at start.
- R10: Busy clears at the clock edge that accepts the last command. If end ≤ start in range mode, or the operation code is 0, busy clears at the edge after the start and no command is issued.
- R11: While busy, writes to offsets 0x20, 0x24 and 0x28 have no effect. Writes to 0x00 and 0x04 still take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte offset of register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid with bus_ready |
| bus_ready | output | 1 | Access completed (one cycle after strobe) |
| cache_en | output | 1 | Global cache enable |
| evt_en | output | 1 | Auxiliary event enable |
| ecc_en | output | 1 | Auxiliary ECC enable |
| line_valid | output | 1 | Per-line command valid |
| line_ready | input | 1 | Downstream accepts command |
| line_idx | output | LIDX_W | Line or set/way index of command |
| line_op | output | 2 | Operation code of command |

## Verification
The bench builds the block with SETWAYS set to 16 and the default 30-bit line index. This keeps a whole-cache walk short enough to run end to end under several ready patterns. The full index width is kept, so a range ending at the top of the 30-bit space checks the exclusive bound with no wrap. The same setting also lets an end register written with all ones show that bits 31:30 are dropped.

// File: rtl/cmo_pkg.sv
package cmo_pkg;
    localparam int unsigned OFF_GCTL  = 'h00;
    localparam int unsigned OFF_AUX   = 'h04;
    localparam int unsigned OFF_MCTL  = 'h20;
    localparam int unsigned OFF_RSTRT = 'h24;
    localparam int unsigned OFF_REND  = 'h28;

    localparam int unsigned AUX_EVT_BIT = 23;
    localparam int unsigned AUX_ECC_BIT = 8;

    localparam int unsigned MC_GO_BIT    = 0;
    localparam int unsigned MC_OP_LO     = 1;
    localparam int unsigned MC_SCOPE_BIT = 3;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_CLEAN = 2'd1,
        OP_INVAL = 2'd2,
        OP_FLUSH = 2'd3
    } maint_op_e;
endpackage

// File: rtl/cmo_regbank.sv
module cmo_regbank
    import cmo_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int LIDX_W = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_ready,
    input  logic              busy_i,
    output logic              launch_o,
    output logic              launch_scope_o,
    output logic [1:0]        launch_op_o,
    output logic              scope_o,
    output logic [LIDX_W-1:0] rng_start_o,
    output logic [LIDX_W-1:0] rng_end_o,
    output logic              cache_en_o,
    output logic              evt_en_o,
    output logic              ecc_en_o
);
    typedef struct packed {
        logic              en;
        logic              evt;
        logic              ecc;
        logic              scope;
        logic [1:0]        op;
        logic [LIDX_W-1:0] rstart;
        logic [LIDX_W-1:0] rend;
        logic [DATA_W-1:0] rdata;
        logic              ready;
    } rb_state_t;

    rb_state_t s_q, s_d;

    logic              hit_gctl, hit_aux, hit_mctl, hit_rs, hit_re;
    logic              cfg_open;
    logic [DATA_W-1:0] rd_mux;

    always_comb begin
        hit_gctl = (bus_addr == ADDR_W'(OFF_GCTL));
        hit_aux  = (bus_addr == ADDR_W'(OFF_AUX));
        hit_mctl = (bus_addr == ADDR_W'(OFF_MCTL));
        hit_rs   = (bus_addr == ADDR_W'(OFF_RSTRT));
        hit_re   = (bus_addr == ADDR_W'(OFF_REND));
        cfg_open = !busy_i;

        rd_mux = '0;
        if (hit_gctl) begin
            rd_mux[0] = s_q.en;
        end else if (hit_aux) begin
            rd_mux[AUX_EVT_BIT] = s_q.evt;
            rd_mux[AUX_ECC_BIT] = s_q.ecc;
        end else if (hit_mctl) begin
            rd_mux[MC_SCOPE_BIT]         = s_q.scope;
            rd_mux[MC_OP_LO+1:MC_OP_LO]  = s_q.op;
            rd_mux[MC_GO_BIT]            = busy_i;
        end else if (hit_rs) begin
            rd_mux = DATA_W'(s_q.rstart);
        end else if (hit_re) begin
            rd_mux = DATA_W'(s_q.rend);
        end

        s_d       = s_q;
        s_d.ready = bus_wr || bus_rd;
        if (bus_rd) begin
            s_d.rdata = rd_mux;
        end
        if (bus_wr) begin
            if (hit_gctl) begin
                s_d.en = bus_wdata[0];
            end
            if (hit_aux) begin
                s_d.evt = bus_wdata[AUX_EVT_BIT];
                s_d.ecc = bus_wdata[AUX_ECC_BIT];
            end
            if (hit_mctl && cfg_open) begin
                s_d.scope = bus_wdata[MC_SCOPE_BIT];
                s_d.op    = bus_wdata[MC_OP_LO+1:MC_OP_LO];
            end
            if (hit_rs && cfg_open) begin
                s_d.rstart = bus_wdata[LIDX_W-1:0];
            end
            if (hit_re && cfg_open) begin
                s_d.rend = bus_wdata[LIDX_W-1:0];
            end
        end

        launch_o       = bus_wr && hit_mctl && cfg_open && bus_wdata[MC_GO_BIT];
        launch_scope_o = bus_wdata[MC_SCOPE_BIT];
        launch_op_o    = bus_wdata[MC_OP_LO+1:MC_OP_LO];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign bus_rdata   = s_q.rdata;
    assign bus_ready   = s_q.ready;
    assign scope_o     = s_q.scope;
    assign rng_start_o = s_q.rstart;
    assign rng_end_o   = s_q.rend;
    assign cache_en_o  = s_q.en;
    assign evt_en_o    = s_q.evt;
    assign ecc_en_o    = s_q.ecc;
endmodule

// File: rtl/cmo_walker.sv
module cmo_walker
    import cmo_pkg::*;
#(
    parameter int LIDX_W  = 30,
    parameter int SETWAYS = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch_i,
    input  logic              scope_i,
    input  logic [1:0]        op_i,
    input  logic [LIDX_W-1:0] rng_start_i,
    input  logic [LIDX_W-1:0] rng_end_i,
    output logic              busy_o,
    output logic              line_valid,
    input  logic              line_ready,
    output logic [LIDX_W-1:0] line_idx,
    output logic [1:0]        line_op
);
    localparam int CNT_W = LIDX_W + 1;
    localparam logic [CNT_W-1:0] ALL_LIM = CNT_W'(SETWAYS);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cur;
        logic [CNT_W-1:0] lim;
        logic [1:0]       op;
    } wk_state_t;

    wk_state_t        s_q, s_d;
    logic             pending;
    logic [CNT_W-1:0] cur_inc;

    always_comb begin
        pending = s_q.busy && (s_q.cur < s_q.lim);
        cur_inc = s_q.cur + CNT_W'(1);
        s_d     = s_q;

        if (launch_i) begin
            s_d.busy = 1'b1;
            s_d.op   = op_i;
            if (scope_i) begin
                s_d.cur = {1'b0, rng_start_i};
                s_d.lim = {1'b0, rng_end_i};
            end else begin
                s_d.cur = '0;
                s_d.lim = ALL_LIM;
            end
            if (maint_op_e'(op_i) == OP_NONE) begin
                s_d.lim = '0;
            end
        end else if (s_q.busy) begin
            if (pending && line_ready) begin
                s_d.cur = cur_inc;
                if (cur_inc >= s_q.lim) begin
                    s_d.busy = 1'b0;
                end
            end else if (!pending) begin
                s_d.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o     = s_q.busy;
    assign line_valid = pending;
    assign line_idx   = s_q.cur[LIDX_W-1:0];
    assign line_op    = s_q.op;
endmodule

// File: rtl/cmo_range_seq.sv
module cmo_range_seq #(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32,
    parameter int LIDX_W  = 30,
    parameter int SETWAYS = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_ready,
    output logic              cache_en,
    output logic              evt_en,
    output logic              ecc_en,
    output logic              line_valid,
    input  logic              line_ready,
    output logic [LIDX_W-1:0] line_idx,
    output logic [1:0]        line_op
);
    logic              busy;
    logic              launch;
    logic              launch_scope;
    logic [1:0]        launch_op;
    logic              cfg_scope;
    logic [LIDX_W-1:0] rng_start;
    logic [LIDX_W-1:0] rng_end;

    cmo_regbank #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .LIDX_W (LIDX_W)
    ) u_regs (
        .clk            (clk),
        .rst_n          (rst_n),
        .bus_wr         (bus_wr),
        .bus_rd         (bus_rd),
        .bus_addr       (bus_addr),
        .bus_wdata      (bus_wdata),
        .bus_rdata      (bus_rdata),
        .bus_ready      (bus_ready),
        .busy_i         (busy),
        .launch_o       (launch),
        .launch_scope_o (launch_scope),
        .launch_op_o    (launch_op),
        .scope_o        (cfg_scope),
        .rng_start_o    (rng_start),
        .rng_end_o      (rng_end),
        .cache_en_o     (cache_en),
        .evt_en_o       (evt_en),
        .ecc_en_o       (ecc_en)
    );

    cmo_walker #(
        .LIDX_W  (LIDX_W),
        .SETWAYS (SETWAYS)
    ) u_walk (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch_i    (launch),
        .scope_i     (launch_scope),
        .op_i        (launch_op),
        .rng_start_i (rng_start),
        .rng_end_i   (rng_end),
        .busy_o      (busy),
        .line_valid  (line_valid),
        .line_ready  (line_ready),
        .line_idx    (line_idx),
        .line_op     (line_op)
    );
endmodule

// File: rtl/cmo_range_seq_chk.sv
module cmo_range_seq_chk #(
    parameter int ADDR_W  = 8,
    parameter int LIDX_W  = 30,
    parameter int SETWAYS = 1024
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_ready,
    input logic              line_valid,
    input logic              line_ready,
    input logic [LIDX_W-1:0] line_idx,
    input logic [1:0]        line_op,
    input logic              busy,
    input logic              cfg_scope,
    input logic [LIDX_W-1:0] rng_start,
    input logic [LIDX_W-1:0] rng_end
);
    localparam logic [LIDX_W:0] ALL_LIM = (LIDX_W+1)'(SETWAYS);

    AST_READY_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr || bus_rd) |=> bus_ready); // R2

    AST_READY_ONLY_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr || bus_rd) |=> !bus_ready); // R2

    AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (line_valid && !line_ready) |=> (line_valid && $stable(line_idx) && $stable(line_op))); // R9

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (line_valid && line_ready) |=> (!line_valid || line_idx == $past(line_idx) + LIDX_W'(1))); // R7

    AST_OP_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        line_valid |-> (line_op != 2'd0)); // R10

    AST_VALID_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        line_valid |-> busy); // R5

    AST_RANGE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (line_valid && cfg_scope) |-> ({1'b0, line_idx} < {1'b0, rng_end})); // R7

    AST_ALL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (line_valid && !cfg_scope) |-> ({1'b0, line_idx} < ALL_LIM)); // R8

    AST_IDLE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !line_valid) |=> !busy); // R10

    AST_START_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_wr && bus_addr == ADDR_W'('h24)) |=> (rng_start == $past(rng_start))); // R11

    AST_END_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_wr && bus_addr == ADDR_W'('h28)) |=> (rng_end == $past(rng_end))); // R11
endmodule

bind cmo_range_seq cmo_range_seq_chk #(
    .ADDR_W  (ADDR_W),
    .LIDX_W  (LIDX_W),
    .SETWAYS (SETWAYS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_ready  (bus_ready),
    .line_valid (line_valid),
    .line_ready (line_ready),
    .line_idx   (line_idx),
    .line_op    (line_op),
    .busy       (busy),
    .cfg_scope  (cfg_scope),
    .rng_start  (rng_start),
    .rng_end    (rng_end)
);

// File: tb/cmo_range_seq_tb.sv
`timescale 1ns/1ps
module cmo_range_seq_tb;
    localparam int AW = 8;
    localparam int DW = 32;
    localparam int LW = 30;
    localparam int NS = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          bus_ready;
    logic          cache_en, evt_en, ecc_en;
    logic          line_valid;
    logic          line_ready = 1'b1;
    logic [LW-1:0] line_idx;
    logic [1:0]    line_op;

    always #2 clk = ~clk;

    cmo_range_seq #(.ADDR_W(AW), .DATA_W(DW), .LIDX_W(LW), .SETWAYS(NS)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready), .cache_en(cache_en), .evt_en(evt_en), .ecc_en(ecc_en),
        .line_valid(line_valid), .line_ready(line_ready), .line_idx(line_idx),
        .line_op(line_op)
    );

    int vectors = 0;
    int fails   = 0;
    int rdy_mode = 0;
    int cyc = 0;
    string phase_tag = "";

    // reference state
    bit            m_live = 0;
    bit            m_en = 0, m_ev = 0, m_ecc = 0, m_scope = 0, m_busy = 0;
    bit [1:0]      m_op = 0, m_wop = 0;
    bit [LW-1:0]   m_start = 0, m_end = 0;
    bit            m_ready = 0;
    bit [DW-1:0]   m_rdata = 0;
    string         m_rtag = "R2";
    string         m_wtag = "R7";
    bit [LW-1:0]   q[$];

    function automatic bit [DW-1:0] ref_read(input bit [AW-1:0] a);
        bit [DW-1:0] v = '0;
        case (a)
            8'h00: v[0] = m_en;
            8'h04: begin v[23] = m_ev; v[8] = m_ecc; end
            8'h20: begin v[3] = m_scope; v[2:1] = m_op; v[0] = m_busy; end
            8'h24: v = DW'(m_start);
            8'h28: v = DW'(m_end);
            default: v = '0;
        endcase
        return v;
    endfunction

    function automatic string addr_tag(input bit [AW-1:0] a);
        case (a)
            8'h00: return "R3";
            8'h04: return "R4";
            8'h20: return "R5";
            8'h24, 8'h28: return "R6";
            default: return "R2";
        endcase
    endfunction

    always @(posedge clk) begin
        bit was_busy;
        cyc++;
        if (!rst_n) begin
            m_en = 0; m_ev = 0; m_ecc = 0; m_scope = 0; m_busy = 0;
            m_op = 0; m_wop = 0; m_start = 0; m_end = 0;
            m_ready = 0; m_rdata = 0; q.delete(); m_live = 1;
        end else begin
            was_busy = m_busy;
            m_ready = bus_wr || bus_rd;
            if (bus_rd) begin
                m_rdata = ref_read(bus_addr);
                m_rtag  = (phase_tag != "") ? phase_tag : addr_tag(bus_addr);
            end
            if (m_busy) begin
                if (q.size() > 0 && line_ready) begin
                    void'(q.pop_front());
                    if (q.size() == 0) m_busy = 0;
                end else if (q.size() == 0) begin
                    m_busy = 0;
                end
            end
            if (bus_wr) begin
                case (bus_addr)
                    8'h00: m_en = bus_wdata[0];
                    8'h04: begin m_ev = bus_wdata[23]; m_ecc = bus_wdata[8]; end
                    8'h20: if (!was_busy) begin
                        m_scope = bus_wdata[3];
                        m_op    = bus_wdata[2:1];
                        if (bus_wdata[0]) begin
                            m_busy = 1;
                            m_wop  = bus_wdata[2:1];
                            m_wtag = bus_wdata[3] ? "R7" : "R8";
                            q.delete();
                            if (bus_wdata[2:1] != 2'd0) begin
                                if (bus_wdata[3]) begin
                                    for (longint i = m_start; i < longint'(m_end); i++) q.push_back(LW'(i));
                                end else begin
                                    for (int i = 0; i < NS; i++) q.push_back(LW'(i));
                                end
                            end
                        end
                    end
                    8'h24: if (!was_busy) m_start = bus_wdata[LW-1:0];
                    8'h28: if (!was_busy) m_end = bus_wdata[LW-1:0];
                    default: ;
                endcase
            end
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s at cycle %0d: actual 0x%0h expected 0x%0h", tag, cyc, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (m_live) begin
            check(cache_en == m_en, "R3", cache_en, m_en);
            check(evt_en == m_ev, "R4", evt_en, m_ev);
            check(ecc_en == m_ecc, "R4", ecc_en, m_ecc);
            check(bus_ready == m_ready, "R2", bus_ready, m_ready);
            if (m_ready) check(bus_rdata == m_rdata, m_rtag, bus_rdata, m_rdata);
            check(line_valid == (m_busy && q.size() > 0), "R9", line_valid, (m_busy && q.size() > 0));
            if (m_busy && q.size() > 0) begin
                check(line_idx == q[0], m_wtag, line_idx, q[0]);
                check(line_op == m_wop, "R9", line_op, m_wop);
            end
        end
    end

    always @(negedge clk) begin
        case (rdy_mode)
            0: line_ready <= 1'b1;
            1: line_ready <= cyc[0];
            default: line_ready <= ($urandom % 3) != 0;
        endcase
    end

    task automatic wr(input bit [AW-1:0] a, input bit [DW-1:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input bit [AW-1:0] a);
        bus_rd = 1; bus_addr = a;
        @(negedge clk);
        bus_rd = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_idle();
        int n = 0;
        while (m_busy && n < 20000) begin
            rd(8'h20);
            n++;
        end
    endtask

    task automatic read_all();
        rd(8'h00); rd(8'h04); rd(8'h20); rd(8'h24); rd(8'h28);
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1;
        idle(1);
        // R1: reset values of every register
        phase_tag = "R1";
        read_all();
        phase_tag = "";
        rd(8'h10);                     // R2 unmapped
        rd(8'hFC);
        // R3 / R4
        wr(8'h00, 32'h1);
        rd(8'h00);
        wr(8'h04, 32'hFFFF_FFFF);
        rd(8'h04);
        wr(8'h04, 32'h0080_0000);
        rd(8'h04);
        // R6 top bits dropped
        wr(8'h28, 32'hFFFF_FFFF);
        rd(8'h28);
        // R7 range clean, ready always high
        rdy_mode = 0;
        wr(8'h24, 32'd5);
        wr(8'h28, 32'd9);
        wr(8'h20, 32'h0000_000B);
        wait_idle();
        rd(8'h20);
        // R8 whole-cache flush, toggling ready
        rdy_mode = 1;
        wr(8'h20, 32'h0000_0007);
        wait_idle();
        // R11 invalidate range with random ready and writes during busy
        rdy_mode = 2;
        wr(8'h24, 32'd100);
        wr(8'h28, 32'd120);
        wr(8'h20, 32'h0000_000D);
        wr(8'h24, 32'd3);
        wr(8'h28, 32'd4);
        wr(8'h20, 32'h0000_0003);
        wr(8'h00, 32'h0);             // R11 still takes effect
        wr(8'h04, 32'h0000_0100);
        phase_tag = "R11";
        read_all();
        phase_tag = "";
        wait_idle();
        read_all();
        // R10 empty ranges and op 0
        rdy_mode = 0;
        phase_tag = "R10";
        wr(8'h28, 32'd100);
        wr(8'h20, 32'h0000_000B);
        rd(8'h20); rd(8'h20);
        wr(8'h28, 32'd50);
        wr(8'h20, 32'h0000_000F);
        rd(8'h20); rd(8'h20);
        wr(8'h20, 32'h0000_0001);
        rd(8'h20); rd(8'h20);
        wr(8'h20, 32'h0000_0009);
        rd(8'h20); rd(8'h20);
        phase_tag = "";
        // R5 field write without start
        wr(8'h20, 32'h0000_000C);
        rd(8'h20);
        // R7 top of index space, exclusive end, random ready
        rdy_mode = 2;
        wr(8'h24, 32'h3FFF_FFFB);
        wr(8'h28, 32'h3FFF_FFFF);
        wr(8'h20, 32'h0000_000F);
        wait_idle();
        read_all();
        // R9 stalled ready then release
        rdy_mode = 1;
        wr(8'h24, 32'd7);
        wr(8'h28, 32'd12);
        wr(8'h20, 32'h0000_000B);
        wait_idle();
        idle(4);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule